// File: doc/BRIEF.md
# Synchronized Reference and Sample Timer

This block derives two phase-locked timing streams from one system clock for a lock-in style measurement front end. A tick divider splits the clock into reference ticks of `TICK_DIV` cycles (100 cycles of a 40 MHz clock gives 2.5 µs). Each tick steps a circular 16-position phase counter. The counter addresses a 16-entry sine table, and the table drives a 4-bit offset-binary code toward an external resistor-ladder DAC. A full period is 16 ticks, which gives a 25 kHz stimulus at a 400 kHz code rate.

A second timer runs from the same clock and issues single-cycle converter strobes. Each strobe sits at a programmable cycle offset inside its tick and carries the phase index of the tick it falls in, so the demodulator knows where in the wave each sample lies. In quarter-rate mode a strobe is issued only in phases 0, 4, 8 and 12, so four samples are taken per period.

A resync pulse at the start of each sample batch clears the tick divider, the phase counter and the sample timer on the same edge. The sampling grid therefore restarts at the start of the wave, and no false phase step appears between batches.

Top module: `ref_sample_timer`

## Requirements
- R1: After a synchronous reset edge: `ref_phase` is 0, `ref_code` is 8, `conv_strobe` is 0 and `sample_phase` is 0.
- R2: `ref_phase` holds for `TICK_DIV` cycles and then increments by one. The first step comes `TICK_DIV` edges after the reset or resync edge, so after edge n (counted from that edge) `ref_phase` equals floor(n / TICK_DIV) mod 16.
- R3: The phase counter is circular: from 15 it wraps to 0 and continues counting.
- R4: `ref_code` equals round(7.5 + 7.5·sin(2πk/16)) for phase k. For k = 0..15 this gives 8, 10, 13, 14, 15, 14, 13, 10, 8, 5, 2, 1, 0, 1, 2, 5.
- R5: At full rate (`rate_sel` = 0), `conv_strobe` is high for exactly one cycle every `TICK_DIV` cycles. With a latched offset `off`, the pulses come after edges n = off + 1 + m·`TICK_DIV`. While a pulse is high, `sample_phase` holds m mod 16, the phase in which the sample point lies. Between pulses, `sample_phase` keeps its last value.
- R6: `sample_offset` is captured only on a reset or resync edge. A value of `TICK_DIV` or above is clamped to `TICK_DIV`-1. A change at any other time has no effect on strobe timing until the next resync.
- R7: A resync pulse clears the tick divider, the phase counter and the sample timer on the same edge. After that edge `ref_phase` is 0 and `conv_strobe` is 0, and the first strobe after it carries phase index 0.
- R8: In quarter-rate mode (`rate_sel` = 1), only the strobes with m mod 4 = 0 are issued, so pulses fall in phases 0, 4, 8 and 12 at the same in-tick offset. The suppressed strobes stay low.
- R9: `rate_sel` is applied at each strobe decision without a resync. A change of rate takes effect from the next strobe position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures `sample_offset` |
| resync | input | 1 | Batch-start pulse; realigns wave and sample grid |
| rate_sel | input | 1 | 0: one strobe per tick; 1: one strobe per four ticks |
| sample_offset | input | OFF_W (7) | Clock-cycle offset of the strobe inside its tick |
| ref_code | output | 4 | Offset-binary code toward the ladder DAC |
| ref_phase | output | 4 | Current phase index of the stimulus |
| conv_strobe | output | 1 | Single-cycle converter trigger |
| sample_phase | output | 4 | Phase index tagged to the latest strobe |

## Verification
Both `ref_phase` and `ref_code` are decoded from state registers. They therefore change on the edge that is a multiple of `TICK_DIV` edges after the last reset or resync edge. `conv_strobe` and `sample_phase` come from a further register stage, so they appear off + 1 edges after that point. The bench counts edges since the last reset or resync and captures the offset and rate on the same edges the design does. It computes the expected values from those counts and the equations above, and compares them on every falling edge, half a cycle away from any input or state change.

// File: rtl/refgen_pkg.sv
package refgen_pkg;

    localparam int PH_W    = 4;
    localparam int CODE_W  = 4;
    localparam int TBL_LEN = 1 << PH_W;
    localparam int QLOW_W  = PH_W - 2;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        RATE_FULL    = 1'b0,
        RATE_QUARTER = 1'b1
    } rate_e;

    typedef struct packed {
        logic   fire;
        phase_t tag;
    } strobe_t;

    // Offset-binary sine codes, round(7.5 + 7.5*sin(2*pi*k/16))
    function automatic code_t sine_code(input phase_t k);
        code_t c;
        case (k)
            4'd0:    c = 4'd8;
            4'd1:    c = 4'd10;
            4'd2:    c = 4'd13;
            4'd3:    c = 4'd14;
            4'd4:    c = 4'd15;
            4'd5:    c = 4'd14;
            4'd6:    c = 4'd13;
            4'd7:    c = 4'd10;
            4'd8:    c = 4'd8;
            4'd9:    c = 4'd5;
            4'd10:   c = 4'd2;
            4'd11:   c = 4'd1;
            4'd12:   c = 4'd0;
            4'd13:   c = 4'd1;
            4'd14:   c = 4'd2;
            default: c = 4'd5;
        endcase
        return c;
    endfunction

    // Quarter rate keeps only phases on the 4-per-period grid
    function automatic logic rate_admits(input rate_e r, input phase_t p);
        return (r == RATE_FULL) || (p[QLOW_W-1:0] == '0);
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV = 100,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: divider never leaves its range
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DIV - 1));

endmodule

// File: rtl/phase_counter.sv
module phase_counter
    import refgen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   tick,
    output phase_t phase
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (tick) begin
            phase <= phase + 1'b1;
        end
    end

    // R2: phase holds between ticks
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!clear && !tick) |=> $stable(phase));

    // R3: circular wrap from last entry to first
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clear && tick && phase == phase_t'(TBL_LEN - 1)) |=> (phase == '0));

endmodule

// File: rtl/sample_timer.sv
module sample_timer
    import refgen_pkg::*;
#(
    parameter int DIV = 100,
    localparam int CW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] offset,
    input  rate_e         rate,
    input  phase_t        phase,
    output strobe_t       strb
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic          hit;
    logic          admit;

    assign load_val = (offset > CW'(DIV - 1)) ? CW'(DIV - 1) : offset;
    assign hit      = (cnt == '0);
    assign admit    = hit && rate_admits(rate, phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= load_val;
            strb <= '0;
        end else if (clear) begin
            cnt       <= load_val;
            strb.fire <= 1'b0;
        end else begin
            cnt       <= hit ? CW'(DIV - 1) : cnt - 1'b1;
            strb.fire <= admit;
            if (admit) begin
                strb.tag <= phase;
            end
        end
    end

    // R5: strobe is a single-cycle pulse
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
        strb.fire |=> !strb.fire);

    // R6: loaded start value never exceeds the tick length
    a_r6_clamped: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt <= CW'(DIV - 1)));

    // R8: quarter-rate strobes fall on the 4-per-period grid
    a_r8_quarter_grid: assert property (@(posedge clk) disable iff (rst)
        (strb.fire && $past(rate) == RATE_QUARTER) |-> (strb.tag[QLOW_W-1:0] == '0));

endmodule

// File: rtl/ref_sample_timer.sv
module ref_sample_timer
    import refgen_pkg::*;
#(
    parameter int TICK_DIV = 100,
    localparam int OFF_W = $clog2(TICK_DIV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              resync,
    input  logic              rate_sel,
    input  logic [OFF_W-1:0]  sample_offset,
    output logic [CODE_W-1:0] ref_code,
    output logic [PH_W-1:0]   ref_phase,
    output logic              conv_strobe,
    output logic [PH_W-1:0]   sample_phase
);
    logic    tick;
    phase_t  phase;
    rate_e   rate;
    strobe_t strb;

    assign rate = rate_e'(rate_sel);

    tick_divider #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (resync),
        .tick  (tick)
    );

    phase_counter u_phase (
        .clk   (clk),
        .rst   (rst),
        .clear (resync),
        .tick  (tick),
        .phase (phase)
    );

    sample_timer #(.DIV(TICK_DIV)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .clear  (resync),
        .offset (sample_offset),
        .rate   (rate),
        .phase  (phase),
        .strb   (strb)
    );

    assign ref_phase    = phase;
    assign ref_code     = sine_code(phase);
    assign conv_strobe  = strb.fire;
    assign sample_phase = strb.tag;

    // R7: resync realigns wave and sample grid together
    a_r7_resync_clears: assert property (@(posedge clk) disable iff (rst)
        resync |=> (ref_phase == '0 && !conv_strobe));

endmodule

// File: tb/ref_sample_timer_tb.sv
`timescale 1ns/1ps
module ref_sample_timer_tb;
    localparam int DIV = 100;
    localparam int OW  = $clog2(DIV);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          resync = 1'b0;
    logic          rate_sel = 1'b0;
    logic [OW-1:0] sample_offset = '0;
    logic [3:0]    ref_code;
    logic [3:0]    ref_phase;
    logic          conv_strobe;
    logic [3:0]    sample_phase;

    always #2 clk = ~clk;

    ref_sample_timer #(.TICK_DIV(DIV)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .resync        (resync),
        .rate_sel      (rate_sel),
        .sample_offset (sample_offset),
        .ref_code      (ref_code),
        .ref_phase     (ref_phase),
        .conv_strobe   (conv_strobe),
        .sample_phase  (sample_phase)
    );

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    // model state: edges since last reset/resync, latched offset
    int n = 0;
    int off_m = 0;
    bit exp_fire = 0;
    int exp_tag = 0;

    function automatic int tbl(int k);
        return int'($floor(7.5 + 7.5 * $sin(2.0 * 3.14159265358979 * k / 16.0) + 0.5));
    endfunction

    function automatic int clampo(int v);
        return (v > DIV - 1) ? DIV - 1 : v;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst || resync) begin
            n        = 0;
            off_m    = clampo(int'(sample_offset));
            exp_fire = 0;
            if (rst) exp_tag = 0;
        end else begin
            n++;
            exp_fire = 0;
            if (n >= off_m + 1 && ((n - off_m - 1) % DIV) == 0) begin
                int m;
                m = (n - off_m - 1) / DIV;
                if (!rate_sel || (m % 4) == 0) begin
                    exp_fire = 1;
                    exp_tag  = m % 16;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            int p;
            p = (n / DIV) % 16;
            chk(cur_req, int'(ref_phase), p);
            chk(cur_req, int'(ref_code), tbl(p));
            chk(cur_req, int'(conv_strobe), int'(exp_fire));
            if (exp_fire) chk(cur_req, int'(sample_phase), exp_tag);
        end
    end

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_resync();
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        sample_offset = 7'd30;
        step(3);
        rst = 1'b0;
        // R1: reset state
        chk("R1", int'(ref_phase), 0);
        chk("R1", int'(ref_code), 8);
        chk("R1", int'(conv_strobe), 0);
        chk("R1", int'(sample_phase), 0);
        chk_on = 1;
        cur_req = "R2";
        step(2000);
        cur_req = "R3";                      // phase wraps 15 -> 0
        step(1700);
        cur_req = "R4";
        step(1700);
        cur_req = "R7";                      // resync, offset 0
        sample_offset = 7'd0;
        pulse_resync();
        step(300);
        cur_req = "R6";                      // offset at tick end, then live change ignored
        sample_offset = 7'd99;
        pulse_resync();
        step(250);
        sample_offset = 7'd10;
        step(400);
        sample_offset = 7'd120;              // clamps to DIV-1
        pulse_resync();
        step(300);
        cur_req = "R8";
        rate_sel = 1'b1;
        sample_offset = 7'd50;
        pulse_resync();
        step(3400);
        cur_req = "R9";
        rate_sel = 1'b0;
        step(900);
        rate_sel = 1'b1;
        step(900);
        cur_req = "R7";                      // resync right at a strobe position
        rate_sel = 1'b0;
        sample_offset = 7'd5;
        pulse_resync();
        step(5);
        pulse_resync();
        step(400);
        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            sample_offset = OW'($urandom_range(0, 127));
            rate_sel = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) != 0) pulse_resync();
            step(int'($urandom_range(50, 3000)));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule